// File: doc/BRIEF.md
# Packed-Element Address Generator

This block turns an element index of a vectorised load or store into a memory address, for the case where the addressed register's elements are narrower than the access. The element stream is treated as packed into blocks, each as wide as the memory operation. Each block takes its base pointer from its own register, counting upward from a starting register number. For every element the block works out three things: which register holds the base pointer, the element's slot inside its block, and the byte address. The byte address is the base pointer plus a signed immediate plus the slot scaled by the element size.

The element width of the addressed register comes from a two-bit code held in that register's control entry. It is independent of the width of the destination register. The operation width comes from a three-bit code. The register file is reached through one combinational read port: the block drives the register number and receives the pointer in the same cycle. Results are registered, so they appear one cycle after the request. When an element is at least as wide as the operation, each block holds exactly one element. An operation-width code outside the defined set raises an error flag.

Top module: `elemaddr_gen`

## Requirements
- R1: The element width code maps to bit widths as follows: 0 gives the native register width (parameter XLEN), 1 gives 8, 2 gives 16 and 3 gives 32.
- R2: The operation width code maps to bit widths as follows: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64 and 4 gives 128.
- R3: The block count per register is the operation bit width divided by the element bit width. The register read is (base register + index / count) modulo the register count. It is shown on `rf_raddr` in the request cycle and on `out_reg_idx` one cycle later.
- R4: `out_sub` equals the index modulo the block count.
- R5: When the element is at least as wide as the operation, the count is one. Then `out_sub` is 0 and the register read is (base register + index) modulo the register count.
- R6: `out_addr` equals the register value read + the sign-extended immediate + `out_sub` × (element bits / 8), modulo 2^XLEN.
- R7: Outputs are registered and appear one cycle after the request. A cycle without `in_valid` gives `out_valid`=0, and all other outputs are 0 in the following cycle.
- R8: Operation width codes 5, 6 and 7 give `out_valid`=1 and `out_err`=1 in the next cycle, with `out_reg_idx`, `out_sub` and `out_addr` equal to 0. Legal codes give `out_err`=0.
- R9: While `rst_n` is low, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| elem_idx | input | IDX_W | Element index within the vector |
| ew_code | input | 2 | Element width code of the addressed register |
| op_code | input | 3 | Memory operation width code |
| base_reg | input | RW | First base register number |
| imm | input | IMM_W | Signed immediate offset |
| rf_raddr | output | RW | Register file read address (combinational) |
| rf_rdata | input | XLEN | Register file read data for `rf_raddr` |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Illegal operation width |
| out_reg_idx | output | RW | Register that supplied the base pointer |
| out_sub | output | SUB_W | Element slot within its block |
| out_addr | output | XLEN | Byte address of the element |

## Verification
The bench builds the block with its defaults: XLEN=64, 32 registers, an 8-bit index and a 12-bit immediate. With a 64-bit native width, code 0 makes elements wider than, or equal to, every operation up to 64 bits, so the one-per-block clamp is reached. The same code with a 128-bit operation gives two elements per block. Byte elements under a 128-bit operation reach the deepest block of 16 slots. Thirty-two registers let a large index push the register read past the top of the file, so the wrap-around is exercised. The 12-bit immediate reaches negative offsets.

// File: rtl/elemaddr_pkg.sv
package elemaddr_pkg;

    typedef enum logic [1:0] {
        EW_NATIVE = 2'd0,
        EW_B8     = 2'd1,
        EW_B16    = 2'd2,
        EW_B32    = 2'd3
    } ew_code_e;

    typedef enum logic [2:0] {
        OP_B8   = 3'd0,
        OP_B16  = 3'd1,
        OP_B32  = 3'd2,
        OP_B64  = 3'd3,
        OP_B128 = 3'd4
    } op_code_e;

    // largest legal operation code
    localparam logic [2:0] OP_CODE_MAX = 3'd4;
    // log2 of the deepest block: 128-bit operation over 8-bit elements
    localparam int MAX_BLK_LG = 4;
    localparam int SUB_W      = MAX_BLK_LG;

endpackage

// File: rtl/elemaddr_width_dec.sv
module elemaddr_width_dec
    import elemaddr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0] ew_code,
    input  logic [2:0] op_code,
    output logic [2:0] el_lg,
    output logic [2:0] blk_lg,
    output logic       illegal
);
    localparam logic [2:0] NATIVE_LG = 3'($clog2(XLEN));

    logic [2:0] op_lg;

    always_comb begin
        unique case (ew_code)
            EW_B8:   el_lg = 3'd3;
            EW_B16:  el_lg = 3'd4;
            EW_B32:  el_lg = 3'd5;
            default: el_lg = NATIVE_LG;
        endcase
        illegal = (op_code > OP_CODE_MAX);
        op_lg   = illegal ? 3'd3 : (op_code + 3'd3);
        // count clamped to one when the element is not narrower than the op
        blk_lg  = (op_lg > el_lg) ? (op_lg - el_lg) : 3'd0;
    end

endmodule

// File: rtl/elemaddr_block_split.sv
module elemaddr_block_split
    import elemaddr_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int RW    = 5
) (
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [2:0]       blk_lg,
    input  logic [RW-1:0]    base_reg,
    output logic [RW-1:0]    reg_idx,
    output logic [SUB_W-1:0] sub
);
    logic [IDX_W-1:0] blk_num;
    logic [SUB_W:0]   span;
    logic [SUB_W-1:0] mask;

    always_comb begin
        blk_num = elem_idx >> blk_lg;
        span    = (SUB_W+1)'(1) << blk_lg;
        mask    = SUB_W'(span - (SUB_W+1)'(1));
        sub     = SUB_W'(elem_idx) & mask;
        reg_idx = base_reg + RW'(blk_num);
    end

endmodule

// File: rtl/elemaddr_addr_sum.sv
module elemaddr_addr_sum
    import elemaddr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [SUB_W-1:0] sub,
    input  logic [2:0]       el_lg,
    output logic [XLEN-1:0]  addr
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] byte_off;

    always_comb begin
        imm_ext  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        byte_off = XLEN'(sub) << (el_lg - 3'd3);
        addr     = base_val + imm_ext + byte_off;
    end

endmodule

// File: rtl/elemaddr_gen.sv
module elemaddr_gen
    import elemaddr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int NREGS = 32,
    parameter int IDX_W = 8,
    parameter int IMM_W = 12,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [1:0]       ew_code,
    input  logic [2:0]       op_code,
    input  logic [RW-1:0]    base_reg,
    input  logic [IMM_W-1:0] imm,
    output logic [RW-1:0]    rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             out_valid,
    output logic             out_err,
    output logic [RW-1:0]    out_reg_idx,
    output logic [SUB_W-1:0] out_sub,
    output logic [XLEN-1:0]  out_addr
);
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [RW-1:0]    ridx;
        logic [SUB_W-1:0] sub;
        logic [XLEN-1:0]  addr;
    } res_s;

    res_s res_d, res_q;

    logic [2:0]       el_lg;
    logic [2:0]       blk_lg;
    logic             illegal;
    logic [RW-1:0]    reg_idx;
    logic [SUB_W-1:0] sub;
    logic [XLEN-1:0]  addr;

    elemaddr_width_dec #(.XLEN(XLEN)) u_dec (
        .ew_code (ew_code),
        .op_code (op_code),
        .el_lg   (el_lg),
        .blk_lg  (blk_lg),
        .illegal (illegal)
    );

    elemaddr_block_split #(.IDX_W(IDX_W), .RW(RW)) u_split (
        .elem_idx (elem_idx),
        .blk_lg   (blk_lg),
        .base_reg (base_reg),
        .reg_idx  (reg_idx),
        .sub      (sub)
    );

    elemaddr_addr_sum #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sum (
        .base_val (rf_rdata),
        .imm      (imm),
        .sub      (sub),
        .el_lg    (el_lg),
        .addr     (addr)
    );

    assign rf_raddr = reg_idx;

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            if (illegal) begin
                res_d.err = 1'b1;
            end else begin
                res_d.ridx = reg_idx;
                res_d.sub  = sub;
                res_d.addr = addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.vld;
    assign out_err     = res_q.err;
    assign out_reg_idx = res_q.ridx;
    assign out_sub     = res_q.sub;
    assign out_addr    = res_q.addr;

endmodule

// File: rtl/elemaddr_chk.sv
module elemaddr_chk
    import elemaddr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 8,
    parameter int RW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IDX_W-1:0] elem_idx,
    input logic [1:0]       ew_code,
    input logic [2:0]       op_code,
    input logic [RW-1:0]    base_reg,
    input logic [RW-1:0]    rf_raddr,
    input logic             out_valid,
    input logic             out_err,
    input logic [RW-1:0]    out_reg_idx,
    input logic [SUB_W-1:0] out_sub,
    input logic [XLEN-1:0]  out_addr
);
    // highest op code whose width does not exceed the native element width
    localparam logic [2:0] NATIVE_OPC = 3'($clog2(XLEN) - 3);

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_err && out_sub == '0 && out_addr == '0));

    p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code > OP_CODE_MAX) |=> (out_err && out_addr == '0 && out_reg_idx == '0));

    p_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code <= OP_CODE_MAX) |=> !out_err);

    p_clamp_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ew_code == EW_NATIVE && op_code <= NATIVE_OPC) |=> out_sub == '0);

    p_clamp_raddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ew_code == EW_NATIVE && op_code <= NATIVE_OPC)
        |-> rf_raddr == RW'(32'(base_reg) + 32'(elem_idx)));

    p_byte_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_B8) |=> out_sub == '0);

    p_reg_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code <= OP_CODE_MAX) |=> out_reg_idx == $past(rf_raddr));

endmodule

bind elemaddr_gen elemaddr_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .RW(RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .elem_idx    (elem_idx),
    .ew_code     (ew_code),
    .op_code     (op_code),
    .base_reg    (base_reg),
    .rf_raddr    (rf_raddr),
    .out_valid   (out_valid),
    .out_err     (out_err),
    .out_reg_idx (out_reg_idx),
    .out_sub     (out_sub),
    .out_addr    (out_addr)
);

// File: tb/sim_elemaddr_gen.sv
`timescale 1ns/1ps
module sim_elemaddr_gen;
    localparam int XLEN  = 64;
    localparam int NREGS = 32;
    localparam int IDX_W = 8;
    localparam int IMM_W = 12;
    localparam int RW    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IDX_W-1:0] elem_idx = '0;
    logic [1:0]       ew_code = '0;
    logic [2:0]       op_code = '0;
    logic [RW-1:0]    base_reg = '0;
    logic [IMM_W-1:0] imm = '0;
    logic [RW-1:0]    rf_raddr;
    logic [XLEN-1:0]  rf_rdata;
    logic             out_valid;
    logic             out_err;
    logic [RW-1:0]    out_reg_idx;
    logic [3:0]       out_sub;
    logic [XLEN-1:0]  out_addr;

    logic [XLEN-1:0] regs [NREGS];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    elemaddr_gen #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W), .IMM_W(IMM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_idx(elem_idx),
        .ew_code(ew_code), .op_code(op_code), .base_reg(base_reg), .imm(imm),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .out_valid(out_valid),
        .out_err(out_err), .out_reg_idx(out_reg_idx), .out_sub(out_sub),
        .out_addr(out_addr)
    );

    function automatic int el_bits(input logic [1:0] c);
        case (c)
            2'd1: return 8;
            2'd2: return 16;
            2'd3: return 32;
            default: return XLEN;
        endcase
    endfunction

    function automatic int op_bits(input logic [2:0] c);
        return 8 << c;
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [IDX_W-1:0] idx, input logic [1:0] ew, input logic [2:0] op,
                       input logic [RW-1:0] base, input logic [IMM_W-1:0] im, input string tag);
        int epb, eb, ridx, sub;
        bit bad;
        logic [XLEN-1:0] ea;
        @(negedge clk);
        elem_idx = idx; ew_code = ew; op_code = op; base_reg = base; imm = im; in_valid = 1'b1;
        bad = (op > 3'd4);
        eb  = el_bits(ew);
        epb = bad ? 1 : op_bits(op) / eb;
        if (epb == 0) epb = 1;
        ridx = (int'(base) + int'(idx) / epb) % NREGS;
        sub  = int'(idx) % epb;
        ea = regs[ridx] + {{(XLEN-IMM_W){im[IMM_W-1]}}, im} + XLEN'(sub * (eb / 8));
        #2;
        if (!bad) check({tag, " R3 raddr"}, XLEN'(rf_raddr), XLEN'(ridx));
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R7 valid"}, XLEN'(out_valid), 1);
        if (bad) begin
            check({tag, " R8 err"}, XLEN'(out_err), 1);
            check({tag, " R8 addr"}, out_addr, 0);
        end else begin
            check({tag, " R8 noerr"}, XLEN'(out_err), 0);
            check({tag, " R3 reg"}, XLEN'(out_reg_idx), XLEN'(ridx));
            check({tag, " R4 sub"}, XLEN'(out_sub), XLEN'(sub));
            check({tag, " R6 addr"}, out_addr, ea);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NREGS; k++) regs[k] = {$urandom(), $urandom()};
        #25;
        check("R9 reset valid", XLEN'(out_valid), 0);
        check("R9 reset addr", out_addr, 0);
        check("R9 reset err", XLEN'(out_err), 0);
        @(negedge clk); rst_n = 1'b1;

        run(8'd5,   2'd2, 3'd2, 5'd3,  12'h010, "R1 R2 half-in-word");
        run(8'd7,   2'd1, 3'd2, 5'd0,  12'h000, "R1 byte-in-word");
        run(8'd37,  2'd1, 3'd4, 5'd10, 12'h004, "R2 byte-in-quad");
        run(8'd3,   2'd0, 3'd4, 5'd1,  12'h000, "R1 native-in-quad");
        run(8'd6,   2'd3, 3'd0, 5'd4,  12'h000, "R5 clamp word-in-byte");
        run(8'd9,   2'd0, 3'd3, 5'd30, 12'h000, "R5 clamp wrap");
        run(8'd200, 2'd2, 3'd1, 5'd0,  12'hFF0, "R6 negative imm");
        run(8'd255, 2'd1, 3'd3, 5'd31, 12'h800, "R3 wrap max index");
        run(8'd4,   2'd1, 3'd6, 5'd2,  12'h001, "R8 illegal");
        run(8'd4,   2'd1, 3'd7, 5'd2,  12'h001, "R8 illegal top");

        @(negedge clk);
        check("R7 idle valid", XLEN'(out_valid), 0);
        check("R7 idle addr", out_addr, 0);
        check("R7 idle sub", XLEN'(out_sub), 0);

        for (int n = 0; n < 300; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 5));
            run(8'($urandom()), 2'($urandom()), op, 5'($urandom()), 12'($urandom()), "rand");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule